// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block keeps the status byte of a serial flash device and decides, one cycle at a time, whether a status update or an array change (page program, sector erase, whole-array erase) may go ahead. A command decoder hands it decoded events: write-enable, write-disable, status-write with its new byte, the moment chip select is released, and program or erase requests with their target address. An array controller reports when a write cycle has finished. An external active-low write-protect pin is brought in through a synchronizer.

The status byte carries a busy flag, a write-enable latch, a two-bit protection level and a lock bit. The protection level fences off none, the upper quarter, the upper half or all of the array. When the lock bit is set and the synchronized pin is low, the status byte is frozen. Whichever of the two happens first, the freeze begins once both hold. Only a high pin lifts it again.

Top module: `flash_status_guard`

## Requirements
- R1: During and right after reset the status byte is 8'h00. Its layout is bit 0 busy, bit 1 write-enable latch, bits 3:2 protection level, bit 7 lock, and bits 6:4 always 0.
- R2: The write-enable latch is set only at a `cs_release` pulse that follows a `cmd_wren` pulse, and shows in the status byte one cycle after that release. A release with no write-enable before it does not set the latch, and neither does a write-enable with no release.
- R3: A `cmd_wrdi` pulse while not busy clears the latch. It also cancels a write-enable that is still waiting for its release.
- R4: A status write while the latch is set, the block is not busy and the hardware lock is off takes effect. `wrsr_ok` pulses in the same cycle. In the next cycle, bit 7 and bits 3:2 of `wrsr_byte` are loaded, the latch is clear and busy is set. The other bits of the byte are dropped.
- R5: A status write while the latch is clear changes nothing.
- R6: `hw_lock` is high while the lock bit is set and the write-protect pin, seen through SYNC_STAGES flops, is low. While it is high a status write is ignored, even with the latch set. The lock is reached either by setting the lock bit with the pin already low or by lowering the pin after the bit is set.
- R7: Write-enable and write-disable do not end the lock. It ends only SYNC_STAGES cycles after the pin goes high.
- R8: `prot_any` and `prot_base` give the fenced range for each level: 0 none (base 0, `prot_any` low), 1 the upper quarter, 2 the upper half, 3 the whole array (base 0).
- R9: A page program (`op_kind` 0) or sector erase (`op_kind` 1) is granted when the latch is set, the block is not busy and the address is outside the fence. A grant sets busy and clears the latch. A request into the fence is refused and clears the latch.
- R10: A whole-array erase (`op_kind` 2) is refused whenever the protection level is nonzero. `op_kind` 3 is always refused.
- R11: While busy, write-enable, write-disable, status writes and requests change nothing, and every request is refused. A `cycle_done` pulse clears busy.
- R12: A request while the latch is clear is refused and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wren | input | 1 | Decoded write-enable instruction |
| cmd_wrdi | input | 1 | Decoded write-disable instruction |
| cmd_wrsr | input | 1 | Decoded status-write instruction, byte complete |
| wrsr_byte | input | 8 | New status byte |
| cs_release | input | 1 | Chip select returned high |
| op_req | input | 1 | Program or erase request |
| op_kind | input | 2 | 0 page, 1 sector, 2 whole array, 3 none |
| op_addr | input | ADDR_W | Target byte address |
| cycle_done | input | 1 | Array write cycle finished |
| wp_n_pin | input | 1 | Write-protect pin, active low, asynchronous |
| status_byte | output | 8 | Status byte as read back |
| hw_lock | output | 1 | Hardware lock in force |
| wrsr_ok | output | 1 | Status write accepted this cycle |
| op_grant | output | 1 | Request accepted this cycle |
| op_refuse | output | 1 | Request refused this cycle |
| prot_any | output | 1 | Some part of the array is fenced |
| prot_base | output | ADDR_W | Lowest fenced address |

## Verification
The bench builds the block with ADDR_W = 10 and SYNC_STAGES = 3. A 1 KiB space puts each quarter boundary at a small address that can be hit exactly, along with the byte just below it. Three synchronizer stages, instead of the default two, show that the lock follows the pin only after the full chain and that a bench expecting two stages would be wrong. Both lock entry orders and the release through the pin are driven against a reference model that tracks the delayed pin in a queue.

// File: rtl/fs_status_pkg.sv
package fs_status_pkg;

  typedef enum logic [1:0] {
    OP_PAGE   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BULK   = 2'd2,
    OP_NONE   = 2'd3
  } fs_op_e;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_LVL0 = 2;
  localparam int BIT_LVL1 = 3;
  localparam int BIT_LOCK = 7;

  // Is a quarter of the array (top two address bits) inside the fence for a level?
  function automatic logic quarter_fenced(input logic [1:0] quarter, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return quarter == 2'b11;
      2'd2:    return quarter[1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // First fenced quarter for a level (0 when nothing or everything is fenced).
  function automatic logic [1:0] fence_start(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return 2'b11;
      2'd2:    return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/fs_wp_sync.sv
module fs_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= pin_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], pin_in};
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/fs_range_check.sv
module fs_range_check
  import fs_status_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  input  fs_op_e            kind,
  output logic              hit,
  output logic              any,
  output logic [ADDR_W-1:0] base
);
  localparam int LOW_W = ADDR_W - 2;

  logic [1:0] quarter;
  logic       addr_hit;

  assign quarter  = addr[ADDR_W-1:ADDR_W-2];
  assign addr_hit = quarter_fenced(quarter, lvl);
  assign any      = |lvl;
  assign base     = {fence_start(lvl), {LOW_W{1'b0}}};
  assign hit      = (kind == OP_BULK) ? any : addr_hit;

  // R8: an address at or above the reported base is fenced
  p_range_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != OP_BULK && any && addr >= base) |-> hit);

  // R8: an address below the reported base is not fenced
  p_range_below_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != OP_BULK && addr < base) |-> !hit);
endmodule

// File: rtl/fs_status_core.sv
module fs_status_core
  import fs_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       cmd_wrsr,
  input  logic [7:0] wrsr_byte,
  input  logic       cs_release,
  input  logic       op_req,
  input  fs_op_e     op_kind,
  input  logic       op_hit,
  input  logic       cycle_done,
  input  logic       wp_sync,
  output logic [7:0] status_byte,
  output logic [1:0] lvl,
  output logic       hw_lock,
  output logic       wrsr_ok,
  output logic       op_grant,
  output logic       op_refuse
);
  logic busy_q, wel_q, arm_q, lock_q;
  logic [1:0] lvl_q;

  logic idle, op_legal, wel_set, wel_drop, arm_clr;

  assign idle     = !busy_q;
  assign hw_lock  = lock_q & ~wp_sync;
  assign wrsr_ok  = cmd_wrsr & idle & wel_q & ~hw_lock;
  assign op_legal = (op_kind != OP_NONE) & ~op_hit;
  assign op_grant = op_req & idle & wel_q & op_legal;
  assign op_refuse = op_req & ~op_grant;

  assign wel_set  = cs_release & arm_q;
  assign wel_drop = wrsr_ok | (op_req & idle) | (cmd_wrdi & idle);
  assign arm_clr  = cs_release | (cmd_wrdi & idle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
      lvl_q  <= 2'b00;
    end else begin
      if (arm_clr)               arm_q <= 1'b0;
      else if (cmd_wren && idle) arm_q <= 1'b1;

      if (wel_drop)     wel_q <= 1'b0;
      else if (wel_set) wel_q <= 1'b1;

      if (wrsr_ok || op_grant) busy_q <= 1'b1;
      else if (cycle_done)     busy_q <= 1'b0;

      if (wrsr_ok) begin
        lock_q <= wrsr_byte[BIT_LOCK];
        lvl_q  <= wrsr_byte[BIT_LVL1:BIT_LVL0];
      end
    end
  end

  always_comb begin
    status_byte           = 8'h00;
    status_byte[BIT_BUSY] = busy_q;
    status_byte[BIT_WEL]  = wel_q;
    status_byte[BIT_LVL1:BIT_LVL0] = lvl_q;
    status_byte[BIT_LOCK] = lock_q;
  end
  assign lvl = lvl_q;

  // R2: latch rises only on the cycle after a chip-select release
  p_wel_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(cs_release));

  // R3: write-disable while idle leaves the latch clear
  p_wrdi_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi && idle) |=> !wel_q);

  // R4: accepted status write loads the lock bit, sets busy, drops the latch
  p_accept_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_ok |=> (busy_q && !wel_q && lock_q == $past(wrsr_byte[BIT_LOCK])));

  // R5: without the latch the writable fields stay put
  p_no_wel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_q |=> ($stable(lock_q) && $stable(lvl_q)));

  // R6: under hardware lock the writable fields stay put
  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> ($stable(lock_q) && $stable(lvl_q)));

  // R7: the lock can only end through the pin going high
  p_lock_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_lock) |-> $rose(wp_sync));

  // R9: a refused request while idle leaves the latch clear
  p_refuse_drops_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_refuse && idle) |=> !wel_q);

  // R9: a grant starts a write cycle
  p_grant_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |=> busy_q);

  // R10: whole-array erase never granted with a nonzero level
  p_bulk_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && op_kind == OP_BULK && lvl_q != 2'b00) |-> !op_grant);

  // R11: nothing is accepted during a write cycle
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!op_grant && !wrsr_ok));
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fs_status_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_byte,
  input  logic              cs_release,
  input  logic              op_req,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              cycle_done,
  input  logic              wp_n_pin,
  output logic [7:0]        status_byte,
  output logic              hw_lock,
  output logic              wrsr_ok,
  output logic              op_grant,
  output logic              op_refuse,
  output logic              prot_any,
  output logic [ADDR_W-1:0] prot_base
);
  fs_op_e     kind;
  logic       wp_sync;
  logic       op_hit;
  logic [1:0] lvl;

  assign kind = fs_op_e'(op_kind);

  fs_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(wp_n_pin), .pin_sync(wp_sync)
  );

  fs_range_check #(.ADDR_W(ADDR_W)) u_range (
    .clk(clk), .rst_n(rst_n), .addr(op_addr), .lvl(lvl), .kind(kind),
    .hit(op_hit), .any(prot_any), .base(prot_base)
  );

  fs_status_core u_core (
    .clk(clk), .rst_n(rst_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_byte(wrsr_byte), .cs_release(cs_release),
    .op_req(op_req), .op_kind(kind), .op_hit(op_hit),
    .cycle_done(cycle_done), .wp_sync(wp_sync),
    .status_byte(status_byte), .lvl(lvl), .hw_lock(hw_lock),
    .wrsr_ok(wrsr_ok), .op_grant(op_grant), .op_refuse(op_refuse)
  );
endmodule

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
  localparam int AW   = 10;
  localparam int SS   = 3;
  localparam int SIZE = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cs_release = 0;
  logic op_req = 0, cycle_done = 0, wp_n_pin = 1;
  logic [7:0] wrsr_byte = 8'h00;
  logic [1:0] op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0] status_byte;
  logic hw_lock, wrsr_ok, op_grant, op_refuse, prot_any;
  logic [AW-1:0] prot_base;

  always #5 clk = ~clk;

  flash_status_guard #(.ADDR_W(AW), .SYNC_STAGES(SS)) i_flash_status_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_byte(wrsr_byte), .cs_release(cs_release),
    .op_req(op_req), .op_kind(op_kind), .op_addr(op_addr),
    .cycle_done(cycle_done), .wp_n_pin(wp_n_pin), .status_byte(status_byte),
    .hw_lock(hw_lock), .wrsr_ok(wrsr_ok), .op_grant(op_grant),
    .op_refuse(op_refuse), .prot_any(prot_any), .prot_base(prot_base)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  bit m_busy, m_wel, m_arm, m_lock;
  int m_lvl;
  bit pinq[$];

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  function automatic int quarters(int lvl);
    if (lvl == 1) return 1;
    if (lvl == 2) return 2;
    if (lvl == 3) return 4;
    return 0;
  endfunction

  function automatic int fence_low(int lvl);
    int q = quarters(lvl);
    if (q == 0) return 0;
    return SIZE - (SIZE / 4) * q;
  endfunction

  function automatic bit fenced(int kind, int addr, int lvl);
    if (kind == 2) return lvl != 0;
    return quarters(lvl) > 0 && addr >= fence_low(lvl);
  endfunction

  function automatic int m_status();
    return (m_lock << 7) | (m_lvl << 2) | (m_wel << 1) | m_busy;
  endfunction

  // one clock: compare at negedge+1, advance model at posedge, clear pulses
  task automatic tick();
    bit locked, acc, grant, refuse;
    #1;
    locked = m_lock && !pinq[0];
    acc    = cmd_wrsr && !m_busy && m_wel && !locked;
    grant  = op_req && !m_busy && m_wel && op_kind != 2'd3 &&
             !fenced(op_kind, op_addr, m_lvl);
    refuse = op_req && !grant;
    cmp("status_byte", status_byte, m_status());
    cmp("hw_lock", hw_lock, locked);
    cmp("wrsr_ok", wrsr_ok, acc);
    cmp("op_grant", op_grant, grant);
    cmp("op_refuse", op_refuse, refuse);
    cmp("prot_any", prot_any, m_lvl != 0);
    cmp("prot_base", prot_base, fence_low(m_lvl));
    @(posedge clk);
    begin
      bit was_busy = m_busy;
      if (cs_release) begin
        if (m_arm) m_wel = 1;
        m_arm = 0;
      end else if (cmd_wrdi && !was_busy) begin
        m_arm = 0;
      end else if (cmd_wren && !was_busy) begin
        m_arm = 1;
      end
      if (cmd_wrdi && !was_busy) m_wel = 0;
      if (acc) begin
        m_lock = wrsr_byte[7];
        m_lvl  = wrsr_byte[3:2];
        m_wel  = 0;
        m_busy = 1;
      end
      if (op_req && !was_busy) m_wel = 0;
      if (grant) m_busy = 1;
      else if (cycle_done && !acc) m_busy = 0;
      pinq.push_back(wp_n_pin);
      void'(pinq.pop_front());
    end
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cs_release = 0;
    op_req = 0; cycle_done = 0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) tick();
  endtask
  task automatic wren_seq();
    cmd_wren = 1; tick();
    cs_release = 1; tick();
  endtask
  task automatic wrsr_seq(logic [7:0] b);
    cmd_wrsr = 1; wrsr_byte = b; tick();
  endtask
  task automatic op_seq(int k, int a);
    op_req = 1; op_kind = 2'(k); op_addr = AW'(a); tick();
  endtask
  task automatic done_seq();
    cycle_done = 1; tick();
  endtask
  task automatic set_level(int lvl);
    wren_seq(); wrsr_seq(8'(lvl << 2)); done_seq();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_busy = 0; m_wel = 0; m_arm = 0; m_lock = 0; m_lvl = 0;
    for (int i = 0; i < SS; i++) pinq.push_back(1'b1);
    repeat (3) @(negedge clk);
    phase = "R1";
    cmp("reset status", status_byte, 8'h00);
    rst_n = 1;
    tick();
    cmp("post-reset status", status_byte, 8'h00);

    phase = "R2";
    cs_release = 1; tick();
    cmp("release alone keeps WEL low", status_byte[1], 0);
    cmd_wren = 1; tick(); idle_cycles(2);
    cmp("wren without release keeps WEL low", status_byte[1], 0);
    cs_release = 1; tick();
    cmp("WEL after release", status_byte[1], 1);

    phase = "R3";
    cmd_wrdi = 1; tick();
    cmp("WEL after wrdi", status_byte[1], 0);
    cmd_wren = 1; tick(); cmd_wrdi = 1; tick(); cs_release = 1; tick();
    cmp("wrdi cancels pending wren", status_byte[1], 0);

    phase = "R5";
    wrsr_seq(8'h8C);
    cmp("status write without WEL", status_byte, 8'h00);

    phase = "R4";
    wren_seq(); wrsr_seq(8'h75);
    cmp("status after write 75", status_byte, 8'h05);
    done_seq();
    cmp("status after done", status_byte, 8'h04);

    phase = "R8";
    cmp("base level 1", prot_base, SIZE * 3 / 4);
    cmp("any level 1", prot_any, 1);

    phase = "R9";
    wren_seq(); op_seq(0, SIZE * 3 / 4 - 1);
    cmp("program just below fence busy", status_byte[0], 1);
    done_seq();
    wren_seq(); op_seq(0, SIZE * 3 / 4);
    cmp("program at fence WEL dropped", status_byte, 8'h04);
    wren_seq(); op_seq(1, SIZE - 1);
    cmp("sector erase top refused", status_byte, 8'h04);

    phase = "R10";
    wren_seq(); op_seq(2, 0);
    cmp("bulk refused level 1", status_byte, 8'h04);
    wren_seq(); op_seq(3, 0);
    cmp("kind 3 refused", status_byte, 8'h04);

    phase = "R8";
    set_level(2);
    cmp("base level 2", prot_base, SIZE / 2);
    wren_seq(); op_seq(0, SIZE / 2 - 1); done_seq();
    wren_seq(); op_seq(0, SIZE / 2);
    set_level(3);
    cmp("base level 3", prot_base, 0);
    wren_seq(); op_seq(0, 0);
    cmp("level 3 fences address 0", status_byte, 8'h0C);
    set_level(0);
    cmp("level 0 nothing fenced", prot_any, 0);

    phase = "R10";
    wren_seq(); op_seq(2, 0);
    cmp("bulk granted level 0", status_byte[0], 1);

    phase = "R11";
    cmd_wren = 1; tick(); cs_release = 1; tick();
    cmp("wren ignored while busy", status_byte[1], 0);
    wrsr_seq(8'h0C); op_seq(0, 5);
    cmp("busy status unchanged", status_byte, 8'h01);
    done_seq();
    cmp("done clears busy", status_byte, 8'h00);

    phase = "R12";
    op_seq(0, 5);
    cmp("request without WEL", status_byte, 8'h00);

    phase = "R6";
    wren_seq(); wrsr_seq(8'h80); done_seq();
    wp_n_pin = 0; idle_cycles(SS - 1);
    cmp("lock not yet through sync", hw_lock, 0);
    tick();
    cmp("lock after sync", hw_lock, 1);
    wren_seq(); wrsr_seq(8'h00);
    cmp("write ignored under lock", status_byte, 8'h82);
    wp_n_pin = 1; idle_cycles(SS + 1);
    wren_seq(); wrsr_seq(8'h00); done_seq();
    wp_n_pin = 0; idle_cycles(SS + 1);
    cmp("no lock with bit clear", hw_lock, 0);
    wren_seq(); wrsr_seq(8'h84); done_seq();
    cmp("lock bit set with pin low", hw_lock, 1);
    wren_seq(); wrsr_seq(8'h00);
    cmp("second order frozen", status_byte, 8'h86);

    phase = "R7";
    cmd_wrdi = 1; tick(); wren_seq();
    cmp("enable does not release", hw_lock, 1);
    wp_n_pin = 1; idle_cycles(SS - 1);
    cmp("still locked inside sync", hw_lock, 1);
    tick();
    cmp("released after sync", hw_lock, 0);
    wrsr_seq(8'h00); done_seq();
    cmp("write accepted after release", status_byte, 8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule